// File: doc/BRIEF.md
# Staged Translation Entry Store

This block keeps a small table of address-translation entries in two arrays. Array 0 is set-associative: 4 sets of 4 ways. The set is picked by two low page-number bits. Array 1 holds 4 entries, and any of them can be selected directly.

Software never touches an entry directly. It fills five 32-bit staging words and then issues a command:

- A **write** command packs the staging words into the chosen entry.
- A **read** command unpacks the chosen entry back into five staging output words.

Two per-array configuration inputs control how a write is stored. One decides whether the page-size code comes from software or from the array's fixed minimum. The other decides whether the invalidation-protect bit is kept.

Each command completes one clock after it is sampled, with a one-cycle done pulse.

Staging word layouts (bit positions):

- **Control word (`ctl`)**
  - array select: bit 28
  - entry/way select: bits 19:16
  - write qualifier: bits 13:12
  - next-victim: bits 3:0
- **Tag word (`tag`)**
  - valid: bit 31
  - protect: bit 30
  - owner id: bits 23:16
  - address-space bit: bit 12
  - size code: bits 11:8
- **Page word (`page`)**
  - page number: bits 31:10
  - storage attributes: bits 4:0
  - array-0 set index: bits 13:12
- **Physical word (`phys`)**
  - physical page low part: bits 31:12
  - user bits: bits 9:6
  - permissions, bits 5:0, from bit 0 upward: user-exec, sup-exec, user-write, sup-write, user-read, sup-read
- **High word (`phys_hi`)**
  - physical page high bits: the low `HI_W` bits

A size code c means a page of 1 KiB × 4^c.

Top module: `tlb_stage_store`

## Requirements
- R1: After reset, `done_o`, `err_o` and all five staging outputs are zero.
- R2: A write followed by a read of the same location returns the following fields unchanged:
  - owner id, address-space bit, page number, attributes, user bits, the six permission bits, the physical low part and the low `HI_W` high bits.
  - Every unused bit reads as zero.
  - In particular, `phys` bits 11:10 read as zero.
- R3: Write qualifier codes:
  - 0 (always) writes the entry.
  - 1 (conditional) writes the entry.
  - 2 (clear reservation) leaves the entry unmodified.
  - 3 (reserved) leaves the entry unmodified.
- R4: When the target array's variable-size flag is set, the stored size code is tag bits 11:8. Otherwise it is that array's configured minimum code.
- R5: The protect bit is stored from tag bit 30 only when the target array's protect-support flag is set; otherwise it is stored as 0.
- R6: A read always returns the tag valid bit as 1, whatever was written. In the control word it returns:
  - the array select and entry select of the location read;
  - the `nv_i` value in bits 3:0;
  - a zero qualifier.
- R7: In array 0, the set is taken from page bits 13:12. Entries in different sets, and entries in array 1, do not alias.
- R8: An entry select of 4 or more raises `err_o` together with `done_o`. On a write it modifies no entry; on a read it leaves the staging outputs unchanged.
- R9: `done_o` pulses for exactly one cycle, on the cycle after each command.
- R10: When write and read commands arrive together, the write is performed and the read is dropped: the staging outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_cmd_i | input | 1 | Write command strobe |
| rd_cmd_i | input | 1 | Read command strobe |
| ctl_i | input | 32 | Control staging word in |
| tag_i | input | 32 | Tag staging word in |
| page_i | input | 32 | Page staging word in |
| phys_i | input | 32 | Physical staging word in |
| phys_hi_i | input | 32 | High physical staging word in |
| nv_i | input | 4 | Next-victim value reported on read |
| cfg_var_size_i | input | 2 | Per-array variable page size allowed |
| cfg_prot_ok_i | input | 2 | Per-array protect bit supported |
| cfg_min_size_i | input | 8 | Per-array minimum size code, 4 bits each (array n at bits 4n+3:4n) |
| done_o | output | 1 | Command complete pulse |
| err_o | output | 1 | Entry select out of range |
| ctl_o | output | 32 | Control staging word out |
| tag_o | output | 32 | Tag staging word out |
| page_o | output | 32 | Page staging word out |
| phys_o | output | 32 | Physical staging word out |
| phys_hi_o | output | 32 | High physical staging word out |

## Verification
The assertions take for granted that command strobes are low while reset is asserted. They also assume the configuration inputs stay steady across a command, so a stored entry depends only on the values sampled at that edge. The stimulus holds commands low through reset and changes the configuration only between commands. It drives every input just after a falling edge, so each command is one clean single-cycle strobe, and it compares readback against words masked from the written values.

// File: rtl/tlb_stage_pkg.sv
package tlb_stage_pkg;
  localparam int TID_W   = 8;
  localparam int HI_W    = 4;
  localparam int SEL_W   = 4;
  localparam int EPN_W   = 22;
  localparam int LO_W    = 20;

  typedef struct packed {
    logic             valid;
    logic             prot;
    logic [TID_W-1:0] tid;
    logic             space;
    logic [3:0]       size;
    logic [EPN_W-1:0] epn;
    logic [4:0]       attr;
    logic [LO_W-1:0]  pa_lo;
    logic [HI_W-1:0]  pa_hi;
    logic [3:0]       ubits;
    logic [5:0]       perm;
  } entry_t;

  localparam int ENTRY_W = $bits(entry_t);
endpackage

// File: rtl/tlb_stage_decode.sv
module tlb_stage_decode #(
  parameter int WAYS   = 4,
  parameter int SETS   = 4,
  parameter int T1_N   = 4,
  parameter int ADDR_W = 5
) (
  input  logic              wr_cmd,
  input  logic              rd_cmd,
  input  logic [31:0]       ctl,
  input  logic [31:0]       page,
  output logic [ADDR_W-1:0] addr,
  output logic              bad,
  output logic              mem_we,
  output logic              do_read
);
  localparam int WAY_B = $clog2(WAYS);
  localparam int SET_B = $clog2(SETS);
  localparam int T1_B  = $clog2(T1_N);
  localparam int T0_N  = WAYS * SETS;

  logic       arr;
  logic [3:0] esel;
  logic [1:0] qual;

  always_comb begin
    arr  = ctl[28];
    esel = ctl[19:16];
    qual = ctl[13:12];
    bad  = arr ? (32'(esel) >= T1_N) : (32'(esel) >= WAYS);
    if (arr)
      addr = ADDR_W'(T0_N) + ADDR_W'(esel[T1_B-1:0]);
    else
      addr = ADDR_W'({page[12 +: SET_B], esel[WAY_B-1:0]});
    mem_we  = wr_cmd && !bad && !qual[1];
    do_read = rd_cmd && !wr_cmd && !bad;
  end
endmodule

// File: rtl/tlb_stage_ram.sv
module tlb_stage_ram #(
  parameter int DEPTH  = 20,
  parameter int WIDTH  = 76,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/tlb_stage_store.sv
module tlb_stage_store
  import tlb_stage_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 4,
  parameter int T1_N = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_cmd_i,
  input  logic        rd_cmd_i,
  input  logic [31:0] ctl_i,
  input  logic [31:0] tag_i,
  input  logic [31:0] page_i,
  input  logic [31:0] phys_i,
  input  logic [31:0] phys_hi_i,
  input  logic [3:0]  nv_i,
  input  logic [1:0]  cfg_var_size_i,
  input  logic [1:0]  cfg_prot_ok_i,
  input  logic [7:0]  cfg_min_size_i,
  output logic        done_o,
  output logic        err_o,
  output logic [31:0] ctl_o,
  output logic [31:0] tag_o,
  output logic [31:0] page_o,
  output logic [31:0] phys_o,
  output logic [31:0] phys_hi_o
);
  localparam int DEPTH  = WAYS * SETS + T1_N;
  localparam int ADDR_W = $clog2(DEPTH);

  logic [ADDR_W-1:0]  addr;
  logic               bad, mem_we, do_read;
  entry_t             wr_e, rd_e;
  logic [ENTRY_W-1:0] rd_raw;
  logic               arr;

  tlb_stage_decode #(.WAYS(WAYS), .SETS(SETS), .T1_N(T1_N), .ADDR_W(ADDR_W)) u_dec (
    .wr_cmd(wr_cmd_i), .rd_cmd(rd_cmd_i), .ctl(ctl_i), .page(page_i),
    .addr(addr), .bad(bad), .mem_we(mem_we), .do_read(do_read)
  );

  tlb_stage_ram #(.DEPTH(DEPTH), .WIDTH(ENTRY_W), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .we(mem_we), .addr(addr), .wdata(wr_e), .rdata(rd_raw)
  );

  assign arr  = ctl_i[28];
  assign rd_e = entry_t'(rd_raw);

  // Pack staging words into one entry, applying per-array configuration.
  always_comb begin
    wr_e.valid = tag_i[31];
    wr_e.prot  = tag_i[30] & (arr ? cfg_prot_ok_i[1] : cfg_prot_ok_i[0]);
    wr_e.tid   = tag_i[16 +: TID_W];
    wr_e.space = tag_i[12];
    if (arr ? cfg_var_size_i[1] : cfg_var_size_i[0])
      wr_e.size = tag_i[11:8];
    else
      wr_e.size = arr ? cfg_min_size_i[7:4] : cfg_min_size_i[3:0];
    wr_e.epn   = page_i[31:10];
    wr_e.attr  = page_i[4:0];
    wr_e.pa_lo = phys_i[31:12];
    wr_e.pa_hi = phys_hi_i[HI_W-1:0];
    wr_e.ubits = phys_i[9:6];
    wr_e.perm  = phys_i[5:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o    <= 1'b0;
      err_o     <= 1'b0;
      ctl_o     <= '0;
      tag_o     <= '0;
      page_o    <= '0;
      phys_o    <= '0;
      phys_hi_o <= '0;
    end else begin
      done_o <= wr_cmd_i | rd_cmd_i;
      err_o  <= (wr_cmd_i | rd_cmd_i) & bad;
      if (do_read) begin
        ctl_o     <= {3'b0, arr, 8'b0, ctl_i[19:16], 12'b0, nv_i};
        tag_o     <= {1'b1, rd_e.prot, {(14-TID_W){1'b0}}, rd_e.tid,
                      3'b0, rd_e.space, rd_e.size, 8'b0};
        page_o    <= {rd_e.epn, 5'b0, rd_e.attr};
        phys_o    <= {rd_e.pa_lo, 2'b0, rd_e.ubits, rd_e.perm};
        phys_hi_o <= {{(32-HI_W){1'b0}}, rd_e.pa_hi};
      end
    end
  end

  p_done_after_cmd_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd_i || rd_cmd_i) |=> done_o);
  p_done_needs_cmd_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(wr_cmd_i || rd_cmd_i));
  p_err_with_done_r8: assert property (@(posedge clk) disable iff (rst)
    err_o |-> done_o);
  p_bad_read_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_cmd_i && !wr_cmd_i && bad) |=> ($stable(phys_o) && $stable(tag_o)));
  p_qual_blocks_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd_i && ctl_i[13]) |-> !mem_we);
  p_read_valid_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_cmd_i && !wr_cmd_i && !bad) |=> tag_o[31]);
  p_write_wins_r10: assert property (@(posedge clk) disable iff (rst)
    wr_cmd_i |=> $stable(page_o));
endmodule

// File: tb/tlb_stage_store_tb.sv
module tlb_stage_store_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_cmd_i = 1'b0, rd_cmd_i = 1'b0;
  logic [31:0] ctl_i = '0, tag_i = '0, page_i = '0, phys_i = '0, phys_hi_i = '0;
  logic [3:0]  nv_i = '0;
  logic [1:0]  cfg_var_size_i = 2'b11, cfg_prot_ok_i = 2'b11;
  logic [7:0]  cfg_min_size_i = 8'h51;
  logic        done_o, err_o;
  logic [31:0] ctl_o, tag_o, page_o, phys_o, phys_hi_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  tlb_stage_store u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ctlw(input logic a, input logic [3:0] e, input logic [1:0] q);
    return {3'b0, a, 8'b0, e, 2'b0, q, 12'b0};
  endfunction

  task automatic cmd(input logic w, input logic r, input logic [31:0] c, input logic [31:0] t,
                     input logic [31:0] p, input logic [31:0] ph, input logic [31:0] hi);
    @(negedge clk);
    wr_cmd_i = w; rd_cmd_i = r; ctl_i = c; tag_i = t; page_i = p; phys_i = ph; phys_hi_i = hi;
    @(negedge clk);
    wr_cmd_i = 1'b0; rd_cmd_i = 1'b0;
  endtask

  task automatic wr(input logic [31:0] c, input logic [31:0] t, input logic [31:0] p,
                    input logic [31:0] ph, input logic [31:0] hi);
    cmd(1'b1, 1'b0, c, t, p, ph, hi);
  endtask

  task automatic rd(input logic [31:0] c, input logic [31:0] p);
    cmd(1'b0, 1'b1, c, 32'h0, p, 32'h0, 32'h0);
  endtask

  task automatic t_reset;
    chk("R1 done", {31'b0, done_o}, 32'h0);
    chk("R1 err", {31'b0, err_o}, 32'h0);
    chk("R1 ctl", ctl_o, 0); chk("R1 tag", tag_o, 0); chk("R1 page", page_o, 0);
    chk("R1 phys", phys_o, 0); chk("R1 hi", phys_hi_o, 0);
  endtask

  task automatic t_roundtrip;
    logic [31:0] t, p, ph, hi;
    t = 32'hC05A_1700; p = 32'hABCD_E415; ph = 32'h1234_5FFF; hi = 32'hFFFF_FFFB;
    nv_i = 4'd3;
    wr(ctlw(1'b1, 4'd2, 2'd0), t, p, ph, hi);
    chk("R9 done after write", {31'b0, done_o}, 32'h1);
    chk("R9 err clear", {31'b0, err_o}, 32'h0);
    @(negedge clk);
    chk("R9 done single pulse", {31'b0, done_o}, 32'h0);
    rd(ctlw(1'b1, 4'd2, 2'd0), 32'h0);
    chk("R9 done after read", {31'b0, done_o}, 32'h1);
    chk("R2 tag", tag_o, t & 32'hC0FF_1F00);
    chk("R2 page", page_o, p & 32'hFFFF_FC1F);
    chk("R2 phys", phys_o, ph & 32'hFFFF_F3FF);
    chk("R2 high", phys_hi_o, 32'hB);
    chk("R6 ctl", ctl_o, 32'h1002_0003);
  endtask

  task automatic t_valid_forced;
    nv_i = 4'd1;
    wr(ctlw(1'b0, 4'd3, 2'd0), 32'h0000_0200, 32'h0000_1000, 32'h0000_0015, 32'h0);
    rd(ctlw(1'b0, 4'd3, 2'd0), 32'h0000_1000);
    chk("R6 valid forced", tag_o, 32'h8000_0200);
    chk("R6 location", ctl_o, 32'h0003_0001);
    chk("R6 perm", phys_o, 32'h15);
  endtask

  task automatic t_qual;
    logic [31:0] c;
    c = ctlw(1'b1, 4'd1, 2'd0);
    wr(c, 32'h8000_0000, 32'h0, 32'hAAAA_A000, 32'h0);
    wr(ctlw(1'b1, 4'd1, 2'd2), 32'h8000_0000, 32'h0, 32'hBBBB_B000, 32'h0);
    rd(c, 32'h0); chk("R3 clear-reservation ignored", phys_o, 32'hAAAA_A000);
    wr(ctlw(1'b1, 4'd1, 2'd3), 32'h8000_0000, 32'h0, 32'hCCCC_C000, 32'h0);
    rd(c, 32'h0); chk("R3 reserved code ignored", phys_o, 32'hAAAA_A000);
    wr(ctlw(1'b1, 4'd1, 2'd1), 32'h8000_0000, 32'h0, 32'hDDDD_D000, 32'h0);
    rd(c, 32'h0); chk("R3 conditional writes", phys_o, 32'hDDDD_D000);
  endtask

  task automatic t_size_prot;
    cfg_var_size_i = 2'b01; cfg_prot_ok_i = 2'b10; cfg_min_size_i = 8'h51;
    wr(ctlw(1'b1, 4'd0, 2'd0), 32'hC000_0700, 32'h0, 32'h0, 32'h0);
    rd(ctlw(1'b1, 4'd0, 2'd0), 32'h0);
    chk("R4 fixed size array1", {28'b0, tag_o[11:8]}, 32'd5);
    chk("R5 protect kept array1", {31'b0, tag_o[30]}, 32'd1);
    wr(ctlw(1'b0, 4'd0, 2'd0), 32'hC000_0700, 32'h0, 32'h0, 32'h0);
    rd(ctlw(1'b0, 4'd0, 2'd0), 32'h0);
    chk("R4 variable size array0", {28'b0, tag_o[11:8]}, 32'd7);
    chk("R5 protect dropped array0", {31'b0, tag_o[30]}, 32'd0);
    cfg_var_size_i = 2'b11; cfg_prot_ok_i = 2'b11;
  endtask

  task automatic t_sets;
    for (int s = 0; s < 4; s++)
      wr(ctlw(1'b0, 4'd0, 2'd0), 32'h8000_0000, 32'(s) << 12, 32'(s + 1) << 12, 32'h0);
    for (int s = 0; s < 4; s++) begin
      rd(ctlw(1'b0, 4'd0, 2'd0), 32'(s) << 12);
      chk("R7 set entry", phys_o, 32'(s + 1) << 12);
    end
    rd(ctlw(1'b1, 4'd2, 2'd0), 32'h0);
    chk("R7 array1 untouched", phys_o, 32'h1234_5FFF & 32'hFFFF_F3FF);
  endtask

  task automatic t_range;
    logic [31:0] held;
    wr(ctlw(1'b1, 4'd5, 2'd0), 32'h8000_0000, 32'h0, 32'h9999_9000, 32'h0);
    chk("R8 write err", {30'b0, done_o, err_o}, 32'h3);
    rd(ctlw(1'b1, 4'd1, 2'd0), 32'h0);
    chk("R8 no entry modified", phys_o, 32'hDDDD_D000);
    held = phys_o;
    rd(ctlw(1'b0, 4'd4, 2'd0), 32'h0);
    chk("R8 read err", {30'b0, done_o, err_o}, 32'h3);
    chk("R8 outputs held", phys_o, held);
  endtask

  task automatic t_both;
    cmd(1'b1, 1'b1, ctlw(1'b1, 4'd3, 2'd0), 32'h8000_0000, 32'h0, 32'h7777_7000, 32'h0);
    chk("R10 read dropped", phys_o, 32'hDDDD_D000);
    rd(ctlw(1'b1, 4'd3, 2'd0), 32'h0);
    chk("R10 write done", phys_o, 32'h7777_7000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_roundtrip;
    t_valid_forced;
    t_qual;
    t_size_prot;
    t_sets;
    t_range;
    t_both;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule